// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block watches a bank of sixteen asynchronous input lines and turns them into a single level-sensitive interrupt. Each line is first resynchronised to the system clock. It is then gated by a sampling enable and filtered by a per-channel debounce window that counts millisecond ticks. A channel raises a sticky status bit when its filtered level equals the polarity software selected for it. Status bits are combined with per-channel interrupt enables into one interrupt output.

Software drives the block through a simple synchronous port with a valid strobe, a write flag, an 8-bit byte address and 32-bit data. A channel is not evaluated at all until software fires its trigger bit. Each trigger restarts that channel's debounce window. Clearing a status bit while the level still matches makes the bit set again on the next cycle. Software can therefore emulate edge detection by flipping the polarity and re-triggering.

Each channel runs a three-state machine:
- **CH_IDLE**: the state after reset; the channel is never evaluated here. A trigger moves it to CH_SETTLE, or to CH_LIVE when the length is zero.
- **CH_SETTLE**: the channel counts ticks while the level holds. A level change or a trigger restarts the count. When the count reaches the length, or the length is zero, it moves to CH_LIVE.
- **CH_LIVE**: the accepted level is compared with the polarity. A level change or a trigger returns the channel to CH_SETTLE, or keeps it in CH_LIVE with the new level when the length is zero.

Top module: `eint_ctrl`

## Requirements
- R1: Reading byte address 0x00 returns, in bit i, the synchronised level of input i ANDed with bit i of the sampling-enable register; bits above the channel count read 0. Read data appears on `reg_rdata` after the clock edge that samples the read request and holds until the next read.
- R2: The sampling-enable (0x04), polarity (0x14) and interrupt-enable (0x18) registers, one bit per channel, read back what was written. The debounce registers at 0x40 + 4*i keep all 32 written bits. Bits [11:0] of each debounce register give channel i's debounce length in millisecond ticks.
- R3: The clear register (0x24) and the trigger register (0x28) always read as zero.
- R4: A channel whose trigger bit has never been written with 1 since reset never sets its status bit, whatever its input does.
- R5: With debounce length 0, the status bit of a triggered channel sets within a few cycles when its gated level equals its polarity bit. Polarity 1 means active-high and 0 means active-low. A channel whose sampling enable is 0 counts as low.
- R6: With debounce length N > 0 and a stable matching input, the status bit stays clear for at least (N-1)*TICK_DIV cycles after the trigger write. It is set no later than (N+1)*TICK_DIV + 4 cycles after that write.
- R7: A level change during the debounce window restarts the count, so the status bit stays clear for at least (N-1)*TICK_DIV cycles after the input returns to a steady level.
- R8: The masked status register (0x20) equals raw status (0x1C) ANDed with interrupt enable. `irq_o` is high exactly when some masked bit is set.
- R9: Writing 1 to a bit of the clear register clears that status bit. If the level still matches, the bit sets again on the following cycle.
- R10: After reset every register reads 0 and `irq_o` is low.
- R11: A status bit stays set after its level stops matching the polarity until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous interrupt input lines |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined level interrupt |

## Verification
The bench builds the block with NCH=16 and DBW=12, so the full bank and the full length field are exercised. It uses TICK_DIV=4, so one millisecond tick lasts four clocks and a debounce window of five ticks closes within about twenty cycles. This lets the early-window and late-window timing bounds and the glitch restart be checked directly. Random pin, enable and polarity patterns cover the active-high, active-low and gated cases together.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_SETTLE = 2'd1,
        CH_LIVE   = 2'd2
    } ch_state_e;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_LEVEL     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SAMPLE_EN = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_POLARITY  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RAW       = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MASKED    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CLEAR     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_TRIG      = 8'h28;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/eint_prescaler.sv
module eint_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/eint_channel.sv
module eint_channel
    import eint_pkg::*;
#(
    parameter int DBW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           level_i,
    input  logic           pol_i,
    input  logic           trig_i,
    input  logic           clr_i,
    input  logic [DBW-1:0] len_i,
    output logic           raw_o
);
    ch_state_e      state_q, state_d;
    logic           db_q, db_d;
    logic [DBW-1:0] cnt_q, cnt_d;
    logic           raw_q, raw_d;
    logic           len_zero;
    logic           window_done;

    assign len_zero    = (len_i == '0);
    assign window_done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            db_q    <= 1'b0;
            cnt_q   <= '0;
            raw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            db_q    <= db_d;
            cnt_q   <= cnt_d;
            raw_q   <= raw_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        db_d    = db_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_IDLE: begin
                if (trig_i) begin
                    db_d    = level_i;
                    cnt_d   = '0;
                    state_d = len_zero ? CH_LIVE : CH_SETTLE;
                end
            end
            CH_SETTLE: begin
                if (trig_i || (level_i != db_q)) begin
                    db_d    = level_i;
                    cnt_d   = '0;
                    state_d = len_zero ? CH_LIVE : CH_SETTLE;
                end else if (len_zero) begin
                    state_d = CH_LIVE;
                end else if (tick_i) begin
                    if (window_done) begin
                        state_d = CH_LIVE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CH_LIVE: begin
                if (trig_i || (level_i != db_q)) begin
                    db_d    = level_i;
                    cnt_d   = '0;
                    state_d = len_zero ? CH_LIVE : CH_SETTLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Outputs: sticky status, clear has priority for one cycle
    always_comb begin
        if (clr_i) begin
            raw_d = 1'b0;
        end else begin
            raw_d = raw_q | ((state_q == CH_LIVE) && (db_q == pol_i));
        end
    end

    assign raw_o = raw_q;
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int DBW      = 12,
    parameter int TICK_DIV = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pin_i,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic [NCH-1:0]    sync_vec, level_vec;
    logic [NCH-1:0]    sample_en_q, pol_q, ie_q;
    logic [NCH-1:0]    raw_stat, masked_stat;
    logic [NCH-1:0]    clr_pulse, trig_pulse;
    logic [DATA_W-1:0] dbnc_q [NCH];
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic              wr_en, rd_en, dbnc_hit, tick;
    logic [3:0]        dbnc_idx;

    assign wr_en    = reg_valid && reg_write;
    assign rd_en    = reg_valid && !reg_write;
    assign dbnc_hit = (reg_addr[7:6] == 2'b01) && (reg_addr[1:0] == 2'b00);
    assign dbnc_idx = reg_addr[5:2];

    assign clr_pulse  = (wr_en && reg_addr == OFS_CLEAR) ? reg_wdata[NCH-1:0] : '0;
    assign trig_pulse = (wr_en && reg_addr == OFS_TRIG)  ? reg_wdata[NCH-1:0] : '0;

    eint_sync #(.W(NCH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (sync_vec)
    );

    eint_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    assign level_vec = sync_vec & sample_en_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        eint_channel #(.DBW(DBW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .level_i(level_vec[g]),
            .pol_i  (pol_q[g]),
            .trig_i (trig_pulse[g]),
            .clr_i  (clr_pulse[g]),
            .len_i  (dbnc_q[g][DBW-1:0]),
            .raw_o  (raw_stat[g])
        );
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_en_q <= '0;
            pol_q       <= '0;
            ie_q        <= '0;
            for (int i = 0; i < NCH; i++) dbnc_q[i] <= '0;
        end else if (wr_en) begin
            if (reg_addr == OFS_SAMPLE_EN) sample_en_q <= reg_wdata[NCH-1:0];
            if (reg_addr == OFS_POLARITY)  pol_q       <= reg_wdata[NCH-1:0];
            if (reg_addr == OFS_IRQ_EN)    ie_q        <= reg_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (dbnc_hit && dbnc_idx == 4'(i)) dbnc_q[i] <= reg_wdata;
            end
        end
    end

    assign masked_stat = raw_stat & ie_q;
    assign irq_o       = |masked_stat;

    // Read path
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            OFS_LEVEL:     rd_mux[NCH-1:0] = level_vec;
            OFS_SAMPLE_EN: rd_mux[NCH-1:0] = sample_en_q;
            OFS_POLARITY:  rd_mux[NCH-1:0] = pol_q;
            OFS_IRQ_EN:    rd_mux[NCH-1:0] = ie_q;
            OFS_RAW:       rd_mux[NCH-1:0] = raw_stat;
            OFS_MASKED:    rd_mux[NCH-1:0] = masked_stat;
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (dbnc_hit && dbnc_idx == 4'(i)) rd_mux = dbnc_q[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk
    import eint_pkg::*;
#(
    parameter int NCH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic [NCH-1:0]    raw,
    input logic [NCH-1:0]    ie,
    input logic [NCH-1:0]    den,
    input logic [NCH-1:0]    clr,
    input logic [NCH-1:0]    trig,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    logic [NCH-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_q | trig;
    end

    AST_NO_SET_BEFORE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~seen_q) == '0); // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((raw & $past(clr)) == '0)); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw != '0) |=> ((($past(raw) & ~$past(clr)) & ~raw) == '0)); // R11

    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq_o); // R8

    AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_addr == OFS_LEVEL)
        |=> ((reg_rdata[NCH-1:0] & ~$past(den)) == '0)); // R1

    AST_PULSE_REGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && (reg_addr == OFS_CLEAR || reg_addr == OFS_TRIG))
        |=> (reg_rdata == '0)); // R3
endmodule

bind eint_ctrl eint_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .raw      (raw_stat),
    .ie       (ie_q),
    .den      (sample_en_q),
    .clr      (clr_pulse),
    .trig     (trig_pulse),
    .reg_valid(reg_valid),
    .reg_write(reg_write),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata)
);

// File: tb/eint_ctrl_tb.sv
module eint_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DIV = 4;

    localparam logic [7:0] A_LEVEL = 8'h00, A_DEN = 8'h04, A_POL = 8'h14, A_IE = 8'h18,
                           A_RAW = 8'h1C, A_MSK = 8'h20, A_CLR = 8'h24, A_TRIG = 8'h28,
                           A_DBNC = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eint_ctrl #(.NCH(NCH), .DBW(12), .TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pins),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input string what, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, what, v, exp);
    endtask

    function automatic logic [15:0] exp_match(input logic [15:0] p, input logic [15:0] en, input logic [15:0] pol);
        return ~((p & en) ^ pol);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] rp, rden, rpol, rie, m;
        void'($urandom(32'd20240611));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R10: reset state
        chk_rd("R10", "sample-enable after reset", A_DEN, 32'h0);
        chk_rd("R10", "polarity after reset", A_POL, 32'h0);
        chk_rd("R10", "irq enable after reset", A_IE, 32'h0);
        chk_rd("R10", "raw after reset", A_RAW, 32'h0);
        chk_rd("R10", "masked after reset", A_MSK, 32'h0);
        chk_rd("R10", "debounce0 after reset", A_DBNC, 32'h0);
        chk("R10", "irq after reset", {31'b0, irq_o}, 32'h0);

        // R2: readback
        rden = 16'($urandom());
        wr(A_DEN, {16'h0, rden});
        chk_rd("R2", "sample-enable readback", A_DEN, {16'h0, rden});
        wr(A_POL, 32'h0000_5A3C);
        chk_rd("R2", "polarity readback", A_POL, 32'h0000_5A3C);
        wr(A_IE, 32'h0000_C3A5);
        chk_rd("R2", "irq enable readback", A_IE, 32'h0000_C3A5);
        wr(A_DBNC + 8'd12, 32'hABCD_E123);
        chk_rd("R2", "debounce3 keeps all bits", A_DBNC + 8'd12, 32'hABCD_E123);
        wr(A_DBNC + 8'd12, 32'h0);

        // R3: pulse registers read zero
        wr(A_CLR, 32'h0000_FFFF);
        chk_rd("R3", "clear reads zero", A_CLR, 32'h0);
        wr(A_TRIG, 32'h0);
        chk_rd("R3", "trigger reads zero", A_TRIG, 32'h0);

        // R4: no status without trigger
        pins = 16'hFFFF;
        wr(A_DEN, 32'hFFFF);
        wr(A_POL, 32'hFFFF);
        wr(A_IE, 32'hFFFF);
        wait_cyc(10);
        chk_rd("R4", "raw without trigger", A_RAW, 32'h0);
        chk("R4", "irq without trigger", {31'b0, irq_o}, 32'h0);

        // R5: length 0, high, low, gated
        wr(A_POL, 32'h0000_FFF9);   // ch1, ch2 active-low
        wr(A_DEN, 32'h0000_FFFB);   // ch2 gated
        pins[1] = 1'b0;
        wait_cyc(4);
        wr(A_TRIG, 32'h0000_0007);
        wait_cyc(3);
        chk_rd("R5", "raw high/low/gated channels", A_RAW, 32'h0000_0007);
        chk("R8", "irq with enabled status", {31'b0, irq_o}, 32'h1);

        // R11: sticky after mismatch
        wr(A_POL, 32'h0000_FFF8);   // ch0 now active-low, pin high
        wait_cyc(4);
        chk_rd("R11", "ch0 status held after mismatch", A_RAW, 32'h0000_0007);

        // R9: clear
        wr(A_CLR, 32'h0000_0001);
        chk_rd("R9", "ch0 cleared", A_RAW, 32'h0000_0006);
        wr(A_CLR, 32'h0000_0002);
        chk_rd("R9", "ch1 sets again while matching", A_RAW, 32'h0000_0006);

        // R8: masking
        wr(A_IE, 32'h0000_0002);
        chk_rd("R8", "masked = raw & enable", A_MSK, 32'h0000_0002);
        wr(A_IE, 32'h0);
        wait_cyc(1);
        chk("R8", "irq low when all disabled", {31'b0, irq_o}, 32'h0);
        chk_rd("R8", "masked zero when disabled", A_MSK, 32'h0);

        // R6: debounce length 5 on fresh channel 5 (pin high, pol high, enabled)
        wr(A_POL, 32'h0000_FFF8);
        wr(A_DBNC + 8'd20, 32'd5);
        wr(A_TRIG, 32'h0000_0020);
        wait_cyc(11);
        rd(A_RAW, v);
        chk("R6", "ch5 still settling early", {31'b0, v[5]}, 32'h0);
        wait_cyc(12);
        rd(A_RAW, v);
        chk("R6", "ch5 set after window", {31'b0, v[5]}, 32'h1);

        // R7: glitch restarts window on fresh channel 6
        wr(A_DBNC + 8'd24, 32'd5);
        wr(A_TRIG, 32'h0000_0040);
        wait_cyc(8);
        pins[6] = 1'b0;
        wait_cyc(2);
        pins[6] = 1'b1;
        wait_cyc(14);
        rd(A_RAW, v);
        chk("R7", "ch6 window restarted by glitch", {31'b0, v[6]}, 32'h0);
        wait_cyc(30);
        rd(A_RAW, v);
        chk("R7", "ch6 set after restarted window", {31'b0, v[6]}, 32'h1);

        // R1/R5/R8: random patterns with length 0
        for (int i = 0; i < NCH; i++) wr(A_DBNC + 8'(4 * i), 32'h0);
        for (int it = 0; it < 20; it++) begin
            rp   = 16'($urandom());
            rden = 16'($urandom());
            rpol = 16'($urandom());
            rie  = 16'($urandom());
            pins = rp;
            wr(A_DEN, {16'h0, rden});
            wr(A_POL, {16'h0, rpol});
            wr(A_IE, {16'h0, rie});
            wr(A_TRIG, 32'h0000_FFFF);
            wait_cyc(4);
            wr(A_CLR, 32'h0000_FFFF);
            wait_cyc(3);
            m = exp_match(rp, rden, rpol);
            chk_rd("R1", "level read gated", A_LEVEL, {16'h0, rp & rden});
            chk_rd("R5", "raw random pattern", A_RAW, {16'h0, m});
            chk_rd("R8", "masked random pattern", A_MSK, {16'h0, m & rie});
            chk("R8", "irq random pattern", {31'b0, irq_o}, {31'b0, |(m & rie)});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule